// File: doc/BRIEF.md
# Repeated String Transfer Engine

This block runs a block-memory operation one element at a time, or repeatedly under a count, against a simple request/acknowledge memory port. A host loads a source offset, a destination offset, an element count and an accumulator. It selects one of five operations (copy, load, store, scan, compare), a byte or word element size, a repeat mode and a direction, and then pulses `start`. The engine walks the offsets and decrements the count. It reads and writes memory and leaves the final offsets, count, accumulator and compare flags on its outputs when `done` pulses.

Segment arithmetic is left to the surrounding logic. Every memory access carries an offset and a one-bit segment tag. The tag is low for the source segment, where reads use the source offset. It is high for the destination segment, where accesses use the destination offset. A repeated compare or scan can end before the count runs out, depending on the zero result of the latest element.

Top module: `strXferEngine`

## Requirements
- R1: Source reads use `srcPtr` with `memDstSeg`=0. Destination reads and all writes use `dstPtr` with `memDstSeg`=1.
- R2: After each element, the pointers the operation used move by 1 (byte) or 2 (word). They move upward when `dirDown`=0 and downward when `dirDown`=1. A pointer the operation does not use keeps its value.
- R3: `opSel` encodings:
  - 0 copies source to destination.
  - 1 loads the source into `acc`. A byte load replaces only the low byte of `acc`.
  - 2 stores `acc` (its low byte in byte mode) to the destination.
  - 3 scans: it compares `acc` with the destination element.
  - 4 compares the source element with the destination element.
  - Codes 5 to 7 finish with no access and leave all state as loaded.
- R4: `repMode` 0 runs one element and leaves `count` unchanged. Modes 1, 2 and 3 decrement `count` once per element, and mode 1 runs until `count` reaches zero.
- R5: With `repMode` nonzero and `countIn`=0, no memory access is made and `done` is high in the cycle right after the `start` edge.
- R6: Flags are all clear after reset. Scan and compare set carry, zero, sign, overflow, parity (even parity of the low byte) and aux (nibble borrow) as for first operand minus second, at the element width. Neither operand is written. Copy, load and store leave the flags unchanged.
- R7: With scan or compare, mode 2 stops after an element whose zero flag is clear, and mode 3 stops after an element whose zero flag is set. For copy, load and store these modes behave like mode 1.
- R8: `memReq` stays high with stable address, segment tag, write enable, size and write data until the cycle `memAck` is sampled high. Each element access, byte or word (`memWord`=1), uses exactly one handshake, and a word is little-endian at the offset.
- R9: After reset the engine is idle, and `busy` is high from the cycle after `start` until `done`. `done` is a one-cycle pulse followed by idle, and `start` is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| opSel | input | 3 | Operation select, see R3 |
| wordMode | input | 1 | 1 = word elements, 0 = byte elements |
| repMode | input | 2 | 0 once, 1 counted, 2 while equal, 3 while unequal |
| dirDown | input | 1 | 1 = pointers step downward |
| srcPtrIn | input | 16 | Initial source offset |
| dstPtrIn | input | 16 | Initial destination offset |
| countIn | input | 16 | Initial element count |
| accIn | input | 16 | Initial accumulator |
| memAck | input | 1 | Memory acknowledge |
| memRdata | input | 16 | Memory read data |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memDstSeg | output | 1 | Segment tag: 0 source, 1 destination |
| memWord | output | 1 | Access size: 1 word, 0 byte |
| memAddr | output | 16 | Access offset |
| memWdata | output | 16 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| srcPtr | output | 16 | Current source offset |
| dstPtr | output | 16 | Current destination offset |
| count | output | 16 | Current element count |
| acc | output | 16 | Accumulator |
| flagCarry | output | 1 | Borrow of the last compare |
| flagZero | output | 1 | Zero result of the last compare |
| flagSign | output | 1 | Result sign of the last compare |
| flagOver | output | 1 | Signed overflow of the last compare |
| flagParity | output | 1 | Even parity of the result low byte |
| flagAux | output | 1 | Borrow out of the low nibble |

## Verification
The bench sweeps every operation, size, direction and repeat mode over counts of 0, 1, 2 and 5, with an acknowledge that stalls irregularly. A design that tested the count after the first access, instead of at start, would touch memory on a zero count. One that took its stop decision from the zero flag of the previous element would run one element too many or too few in the conditional modes. Byte loads that cleared the upper accumulator byte, and word accesses split into two handshakes, show up as accumulator mismatches and wrong handshake counts. Requests that drop or change their address during a stall are caught by the memory model, and so is a start pulse during a long operation that disturbs the running one.

// File: rtl/strXferPkg.sv
`timescale 1ns/1ps
package strXferPkg;

  typedef enum logic [2:0] {
    OP_MOVE    = 3'd0,
    OP_LOAD    = 3'd1,
    OP_STORE   = 3'd2,
    OP_SCAN    = 3'd3,
    OP_COMPARE = 3'd4
  } xferOpE;

  typedef enum logic [1:0] {
    RP_ONCE     = 2'd0,
    RP_COUNT    = 2'd1,
    RP_WHILE_EQ = 2'd2,
    RP_WHILE_NE = 2'd3
  } repModeE;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // take the start values
    logic useDst;    // access uses destination offset / segment
    logic capA;      // capture read data as first operand
    logic capB;      // capture read data as second operand
    logic capAcc;    // capture read data into accumulator
    logic wrTmp;     // write data comes from first operand
    logic cmpAcc;    // compare uses accumulator as first operand
    logic stepSrc;
    logic stepDst;
    logic decCnt;
    logic updFlags;
  } dpStrobeT;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
    logic over;
    logic parity;
    logic aux;
  } flagsT;

  function automatic logic isCompareOp(input logic [2:0] op);
    return (op == OP_SCAN) || (op == OP_COMPARE);
  endfunction

endpackage

// File: rtl/strXferCtrl.sv
`timescale 1ns/1ps
module strXferCtrl
  import strXferPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opSel,
  input  logic [1:0] repMode,
  input  logic       startCntZero,
  input  logic       memAck,
  input  logic       cntIsOne,
  input  logic       cmpZero,
  output dpStrobeT   st,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_SRC, S_RD_DST, S_WR_DST, S_STEP, S_FIN
  } stateE;

  stateE      state, nxt;
  logic [2:0] opQ;
  logic [1:0] repQ;
  logic       earlyStop;

  function automatic stateE firstAccess(input logic [2:0] op);
    case (op)
      OP_STORE: return S_WR_DST;
      OP_SCAN:  return S_RD_DST;
      default:  return S_RD_SRC;
    endcase
  endfunction

  always_comb begin
    nxt       = state;
    st        = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    done      = 1'b0;
    earlyStop = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          st.load = 1'b1;
          if (opSel > OP_COMPARE || (repMode != RP_ONCE && startCntZero))
            nxt = S_FIN;
          else
            nxt = firstAccess(opSel);
        end
      end
      S_RD_SRC: begin
        memReq = 1'b1;
        if (memAck) begin
          if (opQ == OP_LOAD) begin
            st.capAcc = 1'b1;
            nxt       = S_STEP;
          end else begin
            st.capA = 1'b1;
            nxt     = (opQ == OP_COMPARE) ? S_RD_DST : S_WR_DST;
          end
        end
      end
      S_RD_DST: begin
        memReq    = 1'b1;
        st.useDst = 1'b1;
        if (memAck) begin
          st.capB = 1'b1;
          nxt     = S_STEP;
        end
      end
      S_WR_DST: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        st.useDst = 1'b1;
        st.wrTmp  = (opQ == OP_MOVE);
        if (memAck) nxt = S_STEP;
      end
      S_STEP: begin
        st.stepSrc  = (opQ == OP_MOVE) || (opQ == OP_LOAD) || (opQ == OP_COMPARE);
        st.stepDst  = (opQ != OP_LOAD);
        st.decCnt   = (repQ != RP_ONCE);
        st.updFlags = isCompareOp(opQ);
        st.cmpAcc   = (opQ == OP_SCAN);
        earlyStop   = isCompareOp(opQ) &&
                      ((repQ == RP_WHILE_EQ && !cmpZero) ||
                       (repQ == RP_WHILE_NE &&  cmpZero));
        nxt = (repQ != RP_ONCE && !cntIsOne && !earlyStop) ? firstAccess(opQ) : S_FIN;
      end
      S_FIN: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= '0;
      repQ  <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) begin
        opQ  <= opSel;
        repQ <= repMode;
      end
    end
  end

  assign busy = (state != S_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(state) && $stable(memWe)); // R8

  AST_EMPTY_RUN: assert property (@(posedge clk) disable iff (!rstN)
    state == S_IDLE && start && repMode != RP_ONCE && startCntZero |=> done && !memReq); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> $stable(opQ) && $stable(repQ)); // R9

endmodule

// File: rtl/strXferDatapath.sv
`timescale 1ns/1ps
module strXferDatapath
  import strXferPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          st,
  input  logic              wordMode,
  input  logic              dirDown,
  input  logic [ADDR_W-1:0] srcPtrIn,
  input  logic [ADDR_W-1:0] dstPtrIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memDstSeg,
  output logic              memWord,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] acc,
  output flagsT             flags,
  output logic              cntIsOne,
  output logic              cmpZero
);

  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] srcQ, dstQ, stepAmt, nextSrc, nextDst;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] accQ, opAQ, opBQ;
  logic              wordQ, dirQ;
  flagsT             flagsQ, newFlags;

  logic [DATA_W-1:0] cmpA, cmpB, res;
  logic [DATA_W:0]   diffW;
  logic [HALF_W:0]   diffB;
  logic              aMsb, bMsb, rMsb;

  // pointer stepping
  always_comb begin
    stepAmt = wordQ ? ADDR_W'(2) : ADDR_W'(1);
    nextSrc = dirQ ? (srcQ - stepAmt) : (srcQ + stepAmt);
    nextDst = dirQ ? (dstQ - stepAmt) : (dstQ + stepAmt);
  end

  // subtract-style compare at element width
  always_comb begin
    cmpA  = st.cmpAcc ? accQ : opAQ;
    cmpB  = opBQ;
    diffW = {1'b0, cmpA} - {1'b0, cmpB};
    diffB = {1'b0, cmpA[HALF_W-1:0]} - {1'b0, cmpB[HALF_W-1:0]};
    if (wordQ) begin
      newFlags.carry = diffW[DATA_W];
      res            = diffW[DATA_W-1:0];
      aMsb           = cmpA[DATA_W-1];
      bMsb           = cmpB[DATA_W-1];
      rMsb           = diffW[DATA_W-1];
    end else begin
      newFlags.carry = diffB[HALF_W];
      res            = {{HALF_W{1'b0}}, diffB[HALF_W-1:0]};
      aMsb           = cmpA[HALF_W-1];
      bMsb           = cmpB[HALF_W-1];
      rMsb           = diffB[HALF_W-1];
    end
    newFlags.zero   = (res == '0);
    newFlags.sign   = rMsb;
    newFlags.over   = (aMsb ^ bMsb) & (rMsb ^ aMsb);
    newFlags.parity = ~^res[7:0];
    newFlags.aux    = (cmpA[3:0] < cmpB[3:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ   <= '0;
      dstQ   <= '0;
      cntQ   <= '0;
      accQ   <= '0;
      opAQ   <= '0;
      opBQ   <= '0;
      wordQ  <= 1'b0;
      dirQ   <= 1'b0;
      flagsQ <= '0;
    end else begin
      if (st.load) begin
        srcQ  <= srcPtrIn;
        dstQ  <= dstPtrIn;
        cntQ  <= countIn;
        accQ  <= accIn;
        wordQ <= wordMode;
        dirQ  <= dirDown;
      end
      if (st.capA)     opAQ <= memRdata;
      if (st.capB)     opBQ <= memRdata;
      if (st.capAcc)   accQ <= wordQ ? memRdata : {accQ[DATA_W-1:HALF_W], memRdata[HALF_W-1:0]};
      if (st.stepSrc)  srcQ <= nextSrc;
      if (st.stepDst)  dstQ <= nextDst;
      if (st.decCnt)   cntQ <= cntQ - CNT_W'(1);
      if (st.updFlags) flagsQ <= newFlags;
    end
  end

  assign memAddr   = st.useDst ? dstQ : srcQ;
  assign memDstSeg = st.useDst;
  assign memWord   = wordQ;
  assign memWdata  = st.wrTmp ? opAQ : accQ;
  assign srcPtr    = srcQ;
  assign dstPtr    = dstQ;
  assign count     = cntQ;
  assign acc       = accQ;
  assign flags     = flagsQ;
  assign cntIsOne  = (cntQ == CNT_W'(1));
  assign cmpZero   = newFlags.zero;

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.load && !st.stepSrc |=> $stable(srcQ)); // R2

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    st.decCnt |=> cntQ == $past(cntQ) - CNT_W'(1)); // R4

  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !st.updFlags |=> $stable(flagsQ)); // R6

  AST_ACC_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    st.capAcc && !wordQ |=> $stable(accQ[DATA_W-1:HALF_W])); // R3

endmodule

// File: rtl/strXferEngine.sv
`timescale 1ns/1ps
module strXferEngine
  import strXferPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic              wordMode,
  input  logic [1:0]        repMode,
  input  logic              dirDown,
  input  logic [ADDR_W-1:0] srcPtrIn,
  input  logic [ADDR_W-1:0] dstPtrIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic              memDstSeg,
  output logic              memWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] acc,
  output logic              flagCarry,
  output logic              flagZero,
  output logic              flagSign,
  output logic              flagOver,
  output logic              flagParity,
  output logic              flagAux
);

  dpStrobeT st;
  flagsT    flags;
  logic     cntIsOne, cmpZero;

  strXferCtrl ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .opSel        (opSel),
    .repMode      (repMode),
    .startCntZero (countIn == '0),
    .memAck       (memAck),
    .cntIsOne     (cntIsOne),
    .cmpZero      (cmpZero),
    .st           (st),
    .memReq       (memReq),
    .memWe        (memWe),
    .busy         (busy),
    .done         (done)
  );

  strXferDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .wordMode  (wordMode),
    .dirDown   (dirDown),
    .srcPtrIn  (srcPtrIn),
    .dstPtrIn  (dstPtrIn),
    .countIn   (countIn),
    .accIn     (accIn),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memDstSeg (memDstSeg),
    .memWord   (memWord),
    .memWdata  (memWdata),
    .srcPtr    (srcPtr),
    .dstPtr    (dstPtr),
    .count     (count),
    .acc       (acc),
    .flags     (flags),
    .cntIsOne  (cntIsOne),
    .cmpZero   (cmpZero)
  );

  assign flagCarry  = flags.carry;
  assign flagZero   = flags.zero;
  assign flagSign   = flags.sign;
  assign flagOver   = flags.over;
  assign flagParity = flags.parity;
  assign flagAux    = flags.aux;

  AST_WRITE_TAG: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memDstSeg); // R1

endmodule

// File: tb/strXferEngine_test.sv
`timescale 1ns/1ps
module strXferEngine_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [2:0]  opSel;
  logic        wordMode;
  logic [1:0]  repMode;
  logic        dirDown;
  logic [15:0] srcPtrIn, dstPtrIn, countIn, accIn;
  logic        memAck;
  logic [15:0] memRdata;
  logic        memReq, memWe, memDstSeg, memWord;
  logic [15:0] memAddr, memWdata;
  logic        busy, done;
  logic [15:0] srcPtr, dstPtr, count, acc;
  logic        flagCarry, flagZero, flagSign, flagOver, flagParity, flagAux;

  always #2.5 clk = ~clk;

  strXferEngine uut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .wordMode(wordMode),
    .repMode(repMode), .dirDown(dirDown), .srcPtrIn(srcPtrIn), .dstPtrIn(dstPtrIn),
    .countIn(countIn), .accIn(accIn), .memAck(memAck), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memDstSeg(memDstSeg), .memWord(memWord),
    .memAddr(memAddr), .memWdata(memWdata), .busy(busy), .done(done),
    .srcPtr(srcPtr), .dstPtr(dstPtr), .count(count), .acc(acc),
    .flagCarry(flagCarry), .flagZero(flagZero), .flagSign(flagSign),
    .flagOver(flagOver), .flagParity(flagParity), .flagAux(flagAux)
  );

  int total = 0;
  int bad   = 0;

  logic [7:0] dsMem [256];
  logic [7:0] esMem [256];
  logic [7:0] refDs [256];
  logic [7:0] refEs [256];
  logic [5:0] refFl;   // {carry, zero, sign, over, parity, aux}

  int   cyc = 0;
  int   reqCnt = 0;
  int   hsBad = 0;
  int   wordBad = 0;
  bit   curWord;
  bit   pend = 0;
  logic [15:0] pA, pD;
  bit   pW, pS, pWd;
  logic [6:0] stallPat = 7'b1011011;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model with irregular stalls and a handshake monitor
  always @(negedge clk) begin
    bit ackNow;
    logic [7:0] a0, a1;
    cyc++;
    if (!rstN) begin
      memAck = 1'b0;
      pend   = 0;
    end else begin
      if (pend) begin
        if (!memReq || memAddr != pA || memWe != pW || memDstSeg != pS ||
            memWord != pWd || (memWe && memWdata != pD))
          hsBad++;
      end
      ackNow = memReq && stallPat[cyc % 7];
      if (memReq && memWord != curWord) wordBad++;
      if (ackNow) begin
        a0 = memAddr[7:0];
        a1 = a0 + 8'd1;
        reqCnt++;
        if (memWe) begin
          if (memDstSeg) begin
            esMem[a0] = memWdata[7:0];
            if (memWord) esMem[a1] = memWdata[15:8];
          end else begin
            dsMem[a0] = memWdata[7:0];
            if (memWord) dsMem[a1] = memWdata[15:8];
          end
        end else if (memDstSeg) begin
          memRdata = {memWord ? esMem[a1] : 8'h00, esMem[a0]};
        end else begin
          memRdata = {memWord ? dsMem[a1] : 8'h00, dsMem[a0]};
        end
      end
      memAck = ackNow;
      pend   = memReq && !ackNow;
      pA = memAddr; pD = memWdata; pW = memWe; pS = memDstSeg; pWd = memWord;
    end
  end

  function automatic logic [15:0] refRd(input bit dst, input logic [15:0] ad, input bit w);
    logic [7:0] a0, a1;
    a0 = ad[7:0];
    a1 = a0 + 8'd1;
    if (dst) return {w ? refEs[a1] : 8'h00, refEs[a0]};
    return {w ? refDs[a1] : 8'h00, refDs[a0]};
  endfunction

  task automatic refWr(input logic [15:0] ad, input logic [15:0] v, input bit w);
    logic [7:0] a0, a1;
    a0 = ad[7:0];
    a1 = a0 + 8'd1;
    refEs[a0] = v[7:0];
    if (w) refEs[a1] = v[15:8];
  endtask

  function automatic logic [5:0] refCmp(input logic [15:0] a, input logic [15:0] b, input bit w);
    logic [16:0] df;
    logic [15:0] r;
    bit am, bm, rm, cy;
    if (w) begin
      df = {1'b0, a} - {1'b0, b};
      r = df[15:0]; am = a[15]; bm = b[15]; rm = r[15]; cy = df[16];
    end else begin
      df = {9'b0, a[7:0]} - {9'b0, b[7:0]};
      r = {8'h00, df[7:0]}; am = a[7]; bm = b[7]; rm = r[7]; cy = df[8];
    end
    return {cy, (r == 16'h0), rm, (am ^ bm) & (rm ^ am), ~^r[7:0], (a[3:0] < b[3:0])};
  endfunction

  task automatic runOne(input logic [2:0] op, input bit w, input logic [1:0] rp, input bit dn,
                        input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                        input logic [15:0] ac, input bit disturb);
    logic [15:0] eS, eD, eC, eA, va, vb, stp;
    int left, n, nAcc, req0, memMis;
    string cTag;
    eS = s; eD = d; eC = c; eA = ac; nAcc = 0;
    stp = w ? 16'd2 : 16'd1;
    left = (op > 3'd4) ? 0 : ((rp == 2'd0) ? 1 : int'(c));
    while (left > 0) begin
      case (op)
        3'd0: begin
          va = refRd(0, eS, w); refWr(eD, va, w);
          eS = dn ? eS - stp : eS + stp; eD = dn ? eD - stp : eD + stp; nAcc += 2;
        end
        3'd1: begin
          va = refRd(0, eS, w); eA = w ? va : {eA[15:8], va[7:0]};
          eS = dn ? eS - stp : eS + stp; nAcc += 1;
        end
        3'd2: begin
          refWr(eD, eA, w); eD = dn ? eD - stp : eD + stp; nAcc += 1;
        end
        3'd3: begin
          refFl = refCmp(eA, refRd(1, eD, w), w);
          eD = dn ? eD - stp : eD + stp; nAcc += 1;
        end
        default: begin
          va = refRd(0, eS, w); vb = refRd(1, eD, w); refFl = refCmp(va, vb, w);
          eS = dn ? eS - stp : eS + stp; eD = dn ? eD - stp : eD + stp; nAcc += 2;
        end
      endcase
      if (rp != 2'd0) eC = eC - 16'd1;
      left = (rp == 2'd0) ? 0 : int'(eC);
      if (op >= 3'd3 && rp == 2'd2 && !refFl[4]) left = 0;
      if (op >= 3'd3 && rp == 2'd3 &&  refFl[4]) left = 0;
    end

    req0 = reqCnt;
    @(negedge clk);
    opSel = op; wordMode = w; repMode = rp; dirDown = dn;
    srcPtrIn = s; dstPtrIn = d; countIn = c; accIn = ac; curWord = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 4000) begin
      if (disturb && n == 2) begin
        start = 1'b1; opSel = 3'd1; srcPtrIn = 16'h00F0; countIn = 16'd9; accIn = 16'hFFFF;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (!done) begin
      chk(0, "R9 completion timeout", n, 0);
      return;
    end

    cTag = (op >= 3'd3 && rp >= 2'd2) ? "R7 count after conditional repeat" : "R4 count";
    chk(srcPtr == eS, disturb ? "R9 source pointer with start while busy" : "R2 source pointer", srcPtr, eS);
    chk(dstPtr == eD, "R2 destination pointer", dstPtr, eD);
    chk(count == eC, cTag, count, eC);
    chk(acc == eA, "R3 accumulator", acc, eA);
    chk({flagCarry, flagZero, flagSign, flagOver, flagParity, flagAux} == refFl, "R6 flags",
        {flagCarry, flagZero, flagSign, flagOver, flagParity, flagAux}, refFl);
    memMis = 0;
    for (int i = 0; i < 256; i++) begin
      if (dsMem[i] != refDs[i] || esMem[i] != refEs[i]) memMis++;
    end
    chk(memMis == 0, "R1 memory image by segment", memMis, 0);
    chk(reqCnt - req0 == nAcc, "R8 one handshake per element access", reqCnt - req0, nAcc);
    if ((rp != 2'd0 && c == 16'd0) || op > 3'd4)
      chk(n == 0 && reqCnt == req0, "R5 empty run finishes at once", n, 0);
    @(negedge clk);
    chk(!done && !busy, "R9 done is a single pulse", {done, busy}, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] cnts [4];
    int idx;
    cnts[0] = 16'd0; cnts[1] = 16'd1; cnts[2] = 16'd2; cnts[3] = 16'd5;
    rstN = 1'b0; start = 1'b0; opSel = '0; wordMode = 1'b0; repMode = '0; dirDown = 1'b0;
    srcPtrIn = '0; dstPtrIn = '0; countIn = '0; accIn = '0; memAck = 1'b0; memRdata = '0;
    curWord = 0; refFl = '0;
    for (int i = 0; i < 256; i++) begin
      dsMem[i] = 8'((((i * 5) >> 3)) & 3);
      esMem[i] = 8'((((i * 3) >> 3)) & 3);
      refDs[i] = dsMem[i];
      refEs[i] = esMem[i];
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReq, "R9 idle after reset", {busy, done, memReq}, 0);
    chk({flagCarry, flagZero, flagSign, flagOver, flagParity, flagAux} == 6'b0, "R6 flags clear after reset",
        {flagCarry, flagZero, flagSign, flagOver, flagParity, flagAux}, 0);

    idx = 0;
    for (int op = 0; op < 5; op++)
      for (int w = 0; w < 2; w++)
        for (int dn = 0; dn < 2; dn++)
          for (int rp = 0; rp < 4; rp++)
            for (int ci = 0; ci < 4; ci++) begin
              runOne(3'(op), w[0], 2'(rp), dn[0],
                     16'h0040 + 16'((idx * 13) & 8'h3F),
                     16'h0090 + 16'((idx * 11) & 8'h3F),
                     cnts[ci], 16'h0101 * 16'(idx % 4), 1'b0);
              idx++;
            end

    // unused operation codes (R3)
    runOne(3'd5, 1'b1, 2'd1, 1'b0, 16'h0050, 16'h00A0, 16'd3, 16'h1234, 1'b0);
    runOne(3'd7, 1'b0, 2'd0, 1'b1, 16'h0060, 16'h00B0, 16'd2, 16'h00AB, 1'b0);
    // start pulse while busy (R9)
    runOne(3'd2, 1'b1, 2'd1, 1'b0, 16'h0030, 16'h0070, 16'd5, 16'h0302, 1'b1);
    runOne(3'd4, 1'b0, 2'd2, 1'b1, 16'h0080, 16'h00C0, 16'd5, 16'h0000, 1'b1);

    chk(hsBad == 0, "R8 request held stable until acknowledge", hsBad, 0);
    chk(wordBad == 0, "R8 access size matches element width", wordBad, 0);
    summary();
    $finish;
  end

endmodule